// File: doc/BRIEF.md
# Flash ECC Error Capture Unit

This block sits next to the read path of a flash array whose 64-bit words are stored with 8 SECDED check bits. On every array read the decoder reports the outcome through two strobes: one for a corrected single-bit error and one for a detected double-bit error. The unit turns these into two sticky status flags and records the word address and bank of the read that failed. Software clears each flag by writing a one to its clear input.

While a flag is set, the recorded location stays fixed. The first failure is kept until software has seen it and cleared every set flag. A word read as all ones across its 72 stored bits is the erased pattern, and for that pattern a double-bit report cannot be trusted. Such a report is therefore dropped, while single-bit correction still counts.

A one-line read buffer keeps the last word fetched from the array, together with the address and bank it came from. A read that hits this line is answered from the buffer. Any strobes present on that cycle are ignored, because no array check took place. The line is dropped on reset and on a write or erase to the same word.

Top module: `ecc_err_capture`

## Requirements
- R1: A read that misses the buffer with `sec_strobe` high sets `corr_flag` on the next clock edge. The flag then stays high until a cycle with `clr_corr` high and no new corrected event.
- R2: A read that misses the buffer with `ded_strobe` high on a word that is not all ones sets `det_flag` on the next clock edge. The flag then stays high until a cycle with `clr_det` high and no new detected event.
- R3: When both flags are clear, an error event records `rd_addr` into `err_addr` and `rd_bank` into `err_bank` on the next edge.
- R4: While any flag is set and is not being cleared in the same cycle, a further error event leaves `err_addr` and `err_bank` unchanged.
- R5: In a cycle where clears bring every set flag to zero and a new event arrives, the event wins. Its flag is set, and its address and bank are recorded.
- R6: When both strobes arrive on the same read, both flags are set and the location of that read is recorded.
- R7: When all 72 bits of `arr_word` are one (bits 63:0 data, bits 71:64 check), `ded_strobe` is ignored. `sec_strobe` is still honoured.
- R8: A read whose address and bank match the buffered line drives `buf_hit` high in the same cycle. It returns the buffered data on `rd_dout`, and it raises no flag, including after the flags were cleared.
- R9: A write or erase indication (`mod_valid`) whose address and bank match the buffered line makes the next read of that line a miss. An indication for any other address or bank leaves the line in place.
- R10: Synchronous reset clears both flags, sets `err_addr` to 0 and `err_bank` to bank 0, and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | A word read is requested this cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_bank | input | BANK_W | Bank of the read |
| arr_word | input | 72 | Raw stored word: data in 63:0, check bits in 71:64 |
| fix_data | input | 64 | Corrected data from the decoder for this read |
| sec_strobe | input | 1 | Decoder corrected a single-bit error |
| ded_strobe | input | 1 | Decoder detected a double-bit error |
| clr_corr | input | 1 | Write-one-to-clear for the corrected flag |
| clr_det | input | 1 | Write-one-to-clear for the detected flag |
| mod_valid | input | 1 | Write or erase to a word this cycle |
| mod_addr | input | ADDR_W | Word address being written or erased |
| mod_bank | input | BANK_W | Bank being written or erased |
| buf_hit | output | 1 | Current read is served from the buffer |
| rd_dout | output | 64 | Read data, buffered or corrected |
| corr_flag | output | 1 | Sticky corrected-error flag |
| det_flag | output | 1 | Sticky detected-error flag |
| err_addr | output | ADDR_W | Recorded failing word address |
| err_bank | output | BANK_W | Recorded failing bank |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software clear and a new error event. The bench provokes it by raising `clr_det` on the same cycle as a corrected-error read at a fresh address, with the detected flag set beforehand. It then expects the corrected flag high, the detected flag low, and the new location recorded. The second pair is a buffer invalidate and a buffer lookup. The bench drives a same-line and an other-bank write indication between reads, and judges each case by whether the following read reports `buf_hit` and by what `rd_dout` returns.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic sec;
        logic ded;
    } ecc_ev_t;

    function automatic logic is_blank(input code_t w);
        return &w;
    endfunction

endpackage

// File: rtl/ecc_line_buf.sv
module ecc_line_buf
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              look_vld,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic [BANK_W-1:0] look_bank,
    input  data_t             fill_data,
    input  logic              inv_vld,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [BANK_W-1:0] inv_bank,
    output logic              hit,
    output data_t             hit_data
);
    localparam int TAG_W = ADDR_W + BANK_W;

    logic             line_vld;
    logic [TAG_W-1:0] line_tag;
    data_t            line_data;

    logic [TAG_W-1:0] look_tag, inv_tag;
    logic             fill_en, inv_cur, inv_new;

    assign look_tag = {look_bank, look_addr};
    assign inv_tag  = {inv_bank, inv_addr};
    assign hit      = look_vld && line_vld && (line_tag == look_tag);
    assign hit_data = line_data;
    assign fill_en  = look_vld && !hit;
    assign inv_cur  = inv_vld && line_vld && (line_tag == inv_tag);
    assign inv_new  = inv_vld && (look_tag == inv_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld  <= 1'b0;
            line_tag  <= '0;
            line_data <= '0;
        end else if (fill_en) begin
            line_vld  <= !inv_new;
            line_tag  <= look_tag;
            line_data <= fill_data;
        end else if (inv_cur) begin
            line_vld  <= 1'b0;
        end
    end

    // R9: a matching write or erase drops the line
    assert_inval_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (inv_cur && !fill_en) |=> !line_vld);

    // R10: reset leaves the buffer empty
    assert_buf_reset_R10: assert property (@(posedge clk)
        rst |=> !line_vld);

endmodule

// File: rtl/ecc_status_log.sv
module ecc_status_log
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ecc_ev_t           ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [BANK_W-1:0] ev_bank,
    input  logic              clr_sec,
    input  logic              clr_ded,
    output logic              flag_sec,
    output logic              flag_ded,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [BANK_W-1:0] cap_bank
);
    logic any_ev, armed_nx;

    assign any_ev   = ev.sec || ev.ded;
    assign armed_nx = (!flag_sec || clr_sec) && (!flag_ded || clr_ded);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_sec <= 1'b0;
            flag_ded <= 1'b0;
            cap_addr <= '0;
            cap_bank <= '0;
        end else begin
            flag_sec <= ev.sec || (flag_sec && !clr_sec);
            flag_ded <= ev.ded || (flag_ded && !clr_ded);
            if (any_ev && armed_nx) begin
                cap_addr <= ev_addr;
                cap_bank <= ev_bank;
            end
        end
    end

    assert_sec_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (flag_sec && !clr_sec) |=> flag_sec);

    assert_ded_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (flag_ded && !clr_ded) |=> flag_ded);

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (any_ev && !flag_sec && !flag_ded) |=>
            (cap_addr == $past(ev_addr)) && (cap_bank == $past(ev_bank)));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !armed_nx |=> $stable(cap_addr) && $stable(cap_bank));

    assert_clear_race_R5: assert property (@(posedge clk) disable iff (rst)
        (ev.sec && armed_nx) |=> flag_sec && (cap_addr == $past(ev_addr)));

    assert_both_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.sec && ev.ded) |=> flag_sec && flag_ded);

    assert_log_reset_R10: assert property (@(posedge clk)
        rst |=> !flag_sec && !flag_ded && (cap_addr == '0) && (cap_bank == '0));

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [71:0]       arr_word,
    input  logic [63:0]       fix_data,
    input  logic              sec_strobe,
    input  logic              ded_strobe,
    input  logic              clr_corr,
    input  logic              clr_det,
    input  logic              mod_valid,
    input  logic [ADDR_W-1:0] mod_addr,
    input  logic [BANK_W-1:0] mod_bank,
    output logic              buf_hit,
    output logic [63:0]       rd_dout,
    output logic              corr_flag,
    output logic              det_flag,
    output logic [ADDR_W-1:0] err_addr,
    output logic [BANK_W-1:0] err_bank
);
    data_t   buf_data;
    ecc_ev_t ev;
    logic    array_rd, blank;

    ecc_line_buf #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .look_vld  (rd_valid),
        .look_addr (rd_addr),
        .look_bank (rd_bank),
        .fill_data (fix_data),
        .inv_vld   (mod_valid),
        .inv_addr  (mod_addr),
        .inv_bank  (mod_bank),
        .hit       (buf_hit),
        .hit_data  (buf_data)
    );

    assign array_rd = rd_valid && !buf_hit;
    assign blank    = is_blank(arr_word);
    assign ev.sec   = array_rd && sec_strobe;
    assign ev.ded   = array_rd && ded_strobe && !blank;
    assign rd_dout  = buf_hit ? buf_data : fix_data;

    ecc_status_log #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ev_addr  (rd_addr),
        .ev_bank  (rd_bank),
        .clr_sec  (clr_corr),
        .clr_ded  (clr_det),
        .flag_sec (corr_flag),
        .flag_ded (det_flag),
        .cap_addr (err_addr),
        .cap_bank (err_bank)
    );

    // R7: an all-ones word never raises the detected flag
    assert_blank_no_ded_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && (&arr_word) && !det_flag) |=> !det_flag);

    // R8: a buffered read leaves clear flags clear
    assert_hit_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (buf_hit && !corr_flag && !det_flag) |=> !corr_flag && !det_flag);

endmodule

// File: tb/ecc_err_capture_test.sv
module ecc_err_capture_test;

    typedef struct packed {
        logic        rd;
        logic        inv;
        logic [15:0] addr;
        logic        bank;
        logic        sec;
        logic        ded;
        logic        ers;
        logic        cs;
        logic        cd;
        logic        ehit;
        logic        ecorr;
        logic        edet;
        logic [15:0] eaddr;
        logic        ebank;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        //  rd   inv   addr      bk   sec  ded  ers  cs   cd   hit  corr det  eaddr     ebk
        '{1'b1,1'b0,16'h0010,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0}, // R3 clean read
        '{1'b1,1'b0,16'h0010,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0}, // R8 hit ignores strobe
        '{1'b1,1'b0,16'h0020,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0020,1'b1}, // R1 R3
        '{1'b1,1'b0,16'h0030,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0020,1'b1}, // R2 R4 frozen
        '{1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0020,1'b1}, // R1 R2 clear
        '{1'b1,1'b0,16'h0030,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0020,1'b1}, // R8 hit after clear
        '{1'b0,1'b1,16'h0030,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0020,1'b1}, // R9 invalidate
        '{1'b1,1'b0,16'h0030,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0030,1'b0}, // R9 miss, R5 rearm
        '{1'b1,1'b0,16'h0040,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,16'h0040,1'b1}, // R5 clear vs event
        '{1'b1,1'b0,16'h0050,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0040,1'b1}, // R1 clear
        '{1'b1,1'b0,16'h0060,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0060,1'b0}, // R7 blank
        '{1'b1,1'b0,16'h0070,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,16'h0070,1'b1}, // R6 both
        '{1'b1,1'b0,16'h0080,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0070,1'b1}  // R7 blank ded only
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [0:0]  rd_bank = '0;
    logic [71:0] arr_word = '0;
    logic [63:0] fix_data = '0;
    logic        sec_strobe = 1'b0;
    logic        ded_strobe = 1'b0;
    logic        clr_corr = 1'b0;
    logic        clr_det = 1'b0;
    logic        mod_valid = 1'b0;
    logic [15:0] mod_addr = '0;
    logic [0:0]  mod_bank = '0;
    logic        buf_hit;
    logic [63:0] rd_dout;
    logic        corr_flag;
    logic        det_flag;
    logic [15:0] err_addr;
    logic [0:0]  err_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ecc_err_capture #(.ADDR_W(16), .BANK_W(1)) uut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .arr_word(arr_word), .fix_data(fix_data), .sec_strobe(sec_strobe),
        .ded_strobe(ded_strobe), .clr_corr(clr_corr), .clr_det(clr_det),
        .mod_valid(mod_valid), .mod_addr(mod_addr), .mod_bank(mod_bank),
        .buf_hit(buf_hit), .rd_dout(rd_dout), .corr_flag(corr_flag), .det_flag(det_flag),
        .err_addr(err_addr), .err_bank(err_bank)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_valid = 1'b0; sec_strobe = 1'b0; ded_strobe = 1'b0;
        clr_corr = 1'b0; clr_det = 1'b0; mod_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic b, input logic [63:0] d);
        idle();
        rd_valid = 1'b1; rd_addr = a; rd_bank = b; fix_data = d;
        arr_word = {8'h00, d};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 corr_flag", {63'b0, corr_flag}, 64'd0);
        chk("R10 det_flag", {63'b0, det_flag}, 64'd0);
        chk("R10 err_addr", {48'b0, err_addr}, 64'd0);
        chk("R10 err_bank", {63'b0, err_bank}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            rd_valid   = VEC[i].rd;
            rd_addr    = VEC[i].addr;
            rd_bank    = VEC[i].bank;
            fix_data   = {48'h5A5A_0000_1234, VEC[i].addr};
            arr_word   = VEC[i].ers ? {72{1'b1}} : {8'h00, fix_data};
            sec_strobe = VEC[i].sec;
            ded_strobe = VEC[i].ded;
            clr_corr   = VEC[i].cs;
            clr_det    = VEC[i].cd;
            mod_valid  = VEC[i].inv;
            mod_addr   = VEC[i].addr;
            mod_bank   = VEC[i].bank;
            #1;
            chk($sformatf("R8 hit vec%0d", i), {63'b0, buf_hit}, {63'b0, VEC[i].ehit});
            @(posedge clk); #1;
            chk($sformatf("R1 corr vec%0d", i), {63'b0, corr_flag}, {63'b0, VEC[i].ecorr});
            chk($sformatf("R2 det vec%0d", i), {63'b0, det_flag}, {63'b0, VEC[i].edet});
            chk($sformatf("R3 R4 addr vec%0d", i), {48'b0, err_addr}, {48'b0, VEC[i].eaddr});
            chk($sformatf("R3 R4 bank vec%0d", i), {63'b0, err_bank}, {63'b0, VEC[i].ebank});
        end

        // R8: buffered data returned while the array offers different data
        @(negedge clk);
        rd(16'h0090, 1'b1, 64'h1111_2222_3333_4444);
        @(negedge clk);
        rd(16'h0090, 1'b1, 64'h9999_8888_7777_6666);
        sec_strobe = 1'b1;
        #1;
        chk("R8 hit", {63'b0, buf_hit}, 64'd1);
        chk("R8 dout", rd_dout, 64'h1111_2222_3333_4444);
        @(posedge clk); #1;
        chk("R8 no flag", {63'b0, corr_flag}, 64'd0);

        // R9: write to same address in another bank keeps the line
        @(negedge clk);
        idle(); mod_valid = 1'b1; mod_addr = 16'h0090; mod_bank = 1'b0;
        @(negedge clk);
        rd(16'h0090, 1'b1, 64'h0);
        #1;
        chk("R9 other bank keeps line", {63'b0, buf_hit}, 64'd1);
        chk("R9 dout", rd_dout, 64'h1111_2222_3333_4444);

        // R9: miss dout passes corrected data
        @(negedge clk);
        idle(); mod_valid = 1'b1; mod_addr = 16'h0090; mod_bank = 1'b1;
        @(negedge clk);
        rd(16'h0090, 1'b1, 64'hABCD);
        #1;
        chk("R9 same line dropped", {63'b0, buf_hit}, 64'd0);
        chk("R9 miss dout", rd_dout, 64'hABCD);

        // R10: reset with flags set and a live line
        @(negedge clk);
        rd(16'h00A0, 1'b1, 64'h77);
        sec_strobe = 1'b1; ded_strobe = 1'b1;
        @(negedge clk);
        idle();
        chk("R6 both set", {62'b0, corr_flag, det_flag}, 64'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 flags", {62'b0, corr_flag, det_flag}, 64'd0);
        chk("R10 addr", {48'b0, err_addr}, 64'd0);
        chk("R10 bank", {63'b0, err_bank}, 64'd0);
        rd(16'h00A0, 1'b1, 64'h77);
        #1;
        chk("R10 buffer empty", {63'b0, buf_hit}, 64'd0);
        @(negedge clk);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule